// File: doc/BRIEF.md
# Translation Lookaside Buffer with Global-Aware Flush

This block caches recent linear-to-physical page translations so that the page walker runs only when a mapping is absent. It is fully associative and holds a mix of small (4 KB) and large (4 MB) page mappings. A lookup presents a linear address and an access type. In the same cycle the block reports a hit together with the physical address and the permission flags, or a miss. On a miss the walker resolves the mapping and installs it through the fill port.

Cached entries never change because memory changes. Only explicit commands remove them. A write to the directory-base register drops every entry that is not marked global. A single-address invalidate drops whichever entry covers the given linear address, whatever its page size. A write access to an entry whose dirty flag is clear reports a miss, so the walker can set the dirty flag in memory and then refill the entry.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, and every lookup reports a miss.
- R2: After a small-page fill, a lookup whose bits [31:12] equal the filled address hits with `lk_paddr = {fl_pfn, lk_vaddr[11:0]}` and returns the filled rw and us flags. A different small page misses.
- R3: A large-page entry (`fl_big=1`) matches any address whose bits [31:22] are equal and returns `lk_paddr = {fl_pfn[19:10], lk_vaddr[21:0]}`. An address outside that 4 MB region misses.
- R4: A write lookup (`lk_write=1`) that matches an entry with a clear dirty flag reports a miss. A read lookup of the same entry hits, and a write lookup of an entry with the dirty flag set hits.
- R5: A pulse on `base_wr` invalidates every non-global entry and leaves entries filled with `fl_global=1` intact.
- R6: A pulse on `inv_valid` removes any entry that covers `inv_vaddr`, small or large, and leaves all other entries unaffected.
- R7: A fill that overlaps no entry goes to the lowest-index invalid slot. When all slots are valid it goes to the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, with wrap, only on such pointer-placed fills.
- R8: A fill whose address is already covered by an entry overwrites that entry in place. It creates no duplicate and does not move the pointer.
- R9: A fill together with an invalidate or a base write in the same cycle installs the new entry, and the invalidation still applies to the other entries.
- R10: A lookup is answered combinationally from the current contents. A fill, invalidate or flush takes effect at the next rising clock edge, so a lookup in the same cycle as a fill still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Lookup linear address |
| lk_write | input | 1 | Lookup is a write access |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address (valid on hit) |
| lk_rw | output | 1 | Writable flag of the hit entry |
| lk_us | output | 1 | User-access flag of the hit entry |
| fl_valid | input | 1 | Install a translation |
| fl_vaddr | input | 32 | Linear address of the fill |
| fl_pfn | input | 20 | Physical frame number (bits [31:12]) |
| fl_big | input | 1 | Fill is a 4 MB page |
| fl_global | input | 1 | Fill survives base-register flush |
| fl_rw | input | 1 | Writable flag |
| fl_us | input | 1 | User-access flag |
| fl_dirty | input | 1 | Dirty flag already set |
| base_wr | input | 1 | Directory-base register written: flush non-global |
| inv_valid | input | 1 | Invalidate the entry covering inv_vaddr |
| inv_vaddr | input | 32 | Linear address to invalidate |

## Verification
The bench probes addresses at the edges of page and region boundaries. A design that compares the wrong address bits would hit outside a large page, or miss inside one. It invalidates a large page through an address deep inside it, which catches an invalidate that compares only small-page tags. It also flushes with a global entry present, which catches a flush that clears everything. After the buffer fills up, it re-fills an address that is already cached and then shows that the next eviction victim is still present. A design that duplicated the entry or advanced the pointer would have evicted it. It also issues a fill and an invalidate in the same cycle, and a lookup in the cycle of a fill, to pin down the write ordering.

// File: rtl/xc_pkg.sv
package xc_pkg;
   parameter int ADDR_W      = 32;
   parameter int SMALL_SHIFT = 12;
   parameter int BIG_SHIFT   = 22;
   localparam int VPN_W      = ADDR_W - SMALL_SHIFT;
   localparam int BIG_CMP_W  = ADDR_W - BIG_SHIFT;
   localparam int PFN_W      = VPN_W;

   typedef struct packed {
      logic             valid;
      logic             big;
      logic             glob;
      logic [VPN_W-1:0] vpn;
      logic [PFN_W-1:0] pfn;
      logic             rw;
      logic             us;
      logic             dirty;
   } xc_ent_t;
endpackage

// File: rtl/xc_match.sv
module xc_match
   import xc_pkg::*;
#(
   parameter int ENTRIES = 16
) (
   input  xc_ent_t [ENTRIES-1:0] ents,
   input  logic [ADDR_W-1:0]     addr,
   output logic [ENTRIES-1:0]    hits
);
   logic [VPN_W-1:0] vpn;
   assign vpn = addr[ADDR_W-1:SMALL_SHIFT];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      logic big_eq, small_eq;
      assign big_eq   = ents[i].vpn[VPN_W-1 -: BIG_CMP_W] == vpn[VPN_W-1 -: BIG_CMP_W];
      assign small_eq = ents[i].vpn == vpn;
      assign hits[i]  = ents[i].valid && (ents[i].big ? big_eq : small_eq);
   end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_en,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] cover_vec,
   output logic [ENTRIES-1:0] sel
);
   logic [IDX_W-1:0]   ptr_q;
   logic [ENTRIES-1:0] first_cover, first_free, ptr_hot;
   logic               any_cover, any_free;

   always_comb begin
      first_cover = '0;
      first_free  = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (cover_vec[i]) first_cover = ENTRIES'(1) << i;
         if (!valid_vec[i]) first_free = ENTRIES'(1) << i;
      end
   end

   assign any_cover = |cover_vec;
   assign any_free  = ~&valid_vec;
   assign ptr_hot   = ENTRIES'(1) << ptr_q;

   always_comb begin
      if (!fill_en)       sel = '0;
      else if (any_cover) sel = first_cover;
      else if (any_free)  sel = first_free;
      else                sel = ptr_hot;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                  ptr_q <= '0;
      else if (fill_en && !any_cover && !any_free) ptr_q <= ptr_q + 1'b1;
   end

   // R7: one slot per fill, never a valid one while a free slot exists
   a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> $onehot(sel));
   a_r7_prefers_free: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !any_cover && any_free) |-> ((sel & valid_vec) == '0));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xc_pkg::*;
#(
   parameter int ENTRIES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       lk_vaddr,
   input  logic              lk_write,
   output logic              lk_hit,
   output logic [31:0]       lk_paddr,
   output logic              lk_rw,
   output logic              lk_us,
   input  logic              fl_valid,
   input  logic [31:0]       fl_vaddr,
   input  logic [19:0]       fl_pfn,
   input  logic              fl_big,
   input  logic              fl_global,
   input  logic              fl_rw,
   input  logic              fl_us,
   input  logic              fl_dirty,
   input  logic              base_wr,
   input  logic              inv_valid,
   input  logic [31:0]       inv_vaddr
);
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must be a power of two of at least 2");
   end
   if (ADDR_W != 32 || BIG_SHIFT <= SMALL_SHIFT) begin : g_bad_geom
      $error("xlat_cache: unsupported address geometry");
   end

   xc_ent_t [ENTRIES-1:0] ent_q;
   logic [ENTRIES-1:0]    valid_vec, glob_vec, lk_match, inv_match, fl_match, fl_sel;
   xc_ent_t               hit_ent, new_ent;
   logic                  any_match;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_vec
      assign valid_vec[i] = ent_q[i].valid;
      assign glob_vec[i]  = ent_q[i].glob;
   end

   xc_match #(.ENTRIES(ENTRIES)) u_lk_match  (.ents(ent_q), .addr(lk_vaddr),  .hits(lk_match));
   xc_match #(.ENTRIES(ENTRIES)) u_inv_match (.ents(ent_q), .addr(inv_vaddr), .hits(inv_match));
   xc_match #(.ENTRIES(ENTRIES)) u_fl_match  (.ents(ent_q), .addr(fl_vaddr),  .hits(fl_match));

   xc_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_en   (fl_valid),
      .valid_vec (valid_vec),
      .cover_vec (fl_match),
      .sel       (fl_sel)
   );

   always_comb begin
      hit_ent   = '0;
      any_match = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (lk_match[i]) begin
            hit_ent   = ent_q[i];
            any_match = 1'b1;
         end
      end
   end

   assign lk_hit   = any_match && !(lk_write && !hit_ent.dirty);
   assign lk_rw    = hit_ent.rw;
   assign lk_us    = hit_ent.us;
   assign lk_paddr = hit_ent.big
                   ? {hit_ent.pfn[PFN_W-1 -: BIG_CMP_W], lk_vaddr[BIG_SHIFT-1:0]}
                   : {hit_ent.pfn, lk_vaddr[SMALL_SHIFT-1:0]};

   always_comb begin
      new_ent       = '0;
      new_ent.valid = 1'b1;
      new_ent.big   = fl_big;
      new_ent.glob  = fl_global;
      new_ent.vpn   = fl_vaddr[ADDR_W-1:SMALL_SHIFT];
      new_ent.pfn   = fl_pfn;
      new_ent.rw    = fl_rw;
      new_ent.us    = fl_us;
      new_ent.dirty = fl_dirty;
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent_q[i] <= '0;
         else if (fl_sel[i])
            ent_q[i] <= new_ent;
         else if ((base_wr && !ent_q[i].glob) || (inv_valid && inv_match[i]))
            ent_q[i].valid <= 1'b0;
      end
   end

   // R8: a lookup address is covered by at most one entry
   a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
   // R5: after a base write without fill, only global entries remain valid
   a_r5_flush_spares_global: assert property (@(posedge clk) disable iff (!rst_n)
      (base_wr && !fl_valid) |=> ((valid_vec & ~glob_vec) == '0));
   // R6: entries covering the invalidated address are gone
   a_r6_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !fl_valid) |=> (($past(inv_match) & valid_vec) == '0));
   // R2: a hit needs some valid entry
   a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (valid_vec != '0));
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
   typedef struct {
      logic [31:0] va;
      logic        wr;
      logic        hit;
      logic [31:0] pa;
      logic        rw;
      logic        us;
      string       req;
   } item_t;

   logic clk = 0, rst_n = 0;
   logic [31:0] lk_vaddr = 0, fl_vaddr = 0, inv_vaddr = 0, lk_paddr;
   logic        lk_write = 0, lk_hit, lk_rw, lk_us;
   logic        fl_valid = 0, fl_big = 0, fl_global = 0, fl_rw = 0, fl_us = 0, fl_dirty = 0;
   logic [19:0] fl_pfn = 0;
   logic        base_wr = 0, inv_valid = 0;
   int checks = 0, errors = 0;
   bit done = 0;
   item_t q[$];

   always #2 clk = ~clk;

   xlat_cache u_xlat_cache (.*);

   task automatic strobes_off();
      fl_valid = 0; base_wr = 0; inv_valid = 0; lk_write = 0;
   endtask

   task automatic push_look(input logic [31:0] va, input logic wr, input logic hit,
                            input logic [31:0] pa, input logic rw, input logic us, input string req);
      item_t it;
      lk_vaddr = va; lk_write = wr;
      it.va = va; it.wr = wr; it.hit = hit; it.pa = pa; it.rw = rw; it.us = us; it.req = req;
      q.push_back(it);
   endtask

   task automatic look(input logic [31:0] va, input logic wr, input logic hit,
                       input logic [31:0] pa, input logic rw, input logic us, input string req);
      @(negedge clk); strobes_off();
      push_look(va, wr, hit, pa, rw, us, req);
   endtask

   task automatic set_fill(input logic [31:0] va, input logic [19:0] pfn, input logic big,
                           input logic glob, input logic rw, input logic us, input logic dirty);
      fl_valid = 1; fl_vaddr = va; fl_pfn = pfn; fl_big = big;
      fl_global = glob; fl_rw = rw; fl_us = us; fl_dirty = dirty;
   endtask

   task automatic fill(input logic [31:0] va, input logic [19:0] pfn, input logic big,
                       input logic glob, input logic rw, input logic us, input logic dirty);
      @(negedge clk); strobes_off();
      set_fill(va, pfn, big, glob, rw, us, dirty);
   endtask

   task automatic inval(input logic [31:0] va);
      @(negedge clk); strobes_off();
      inv_valid = 1; inv_vaddr = va;
   endtask

   // monitor: compares each pushed expectation away from the clock edge
   initial begin
      forever begin
         @(negedge clk); #1;
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (lk_hit !== it.hit) begin
               errors++;
               $display("FAIL %s va=%h hit actual %b expected %b", it.req, it.va, lk_hit, it.hit);
            end else if (it.hit && (lk_paddr !== it.pa || lk_rw !== it.rw || lk_us !== it.us)) begin
               errors++;
               $display("FAIL %s va=%h pa/rw/us actual %h/%b/%b expected %h/%b/%b",
                        it.req, it.va, lk_paddr, lk_rw, lk_us, it.pa, it.rw, it.us);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: empty after reset
      look(32'h1234_5678, 0, 0, 0, 0, 0, "R1");
      look(32'h0000_0000, 0, 0, 0, 0, 0, "R1");
      // R2: small page in slot 0
      fill(32'h0040_1000, 20'hABCDE, 0, 0, 1, 0, 1);
      look(32'h0040_1ABC, 0, 1, 32'hABCD_EABC, 1, 0, "R2");
      look(32'h0040_2000, 0, 0, 0, 0, 0, "R2");
      look(32'h0040_0FFF, 0, 0, 0, 0, 0, "R2");
      // R3: large global page in slot 1
      fill(32'h8000_0000, 20'hC0000, 1, 1, 0, 1, 1);
      look(32'h803F_FFFC, 0, 1, 32'hC03F_FFFC, 0, 1, "R3");
      look(32'h8012_3456, 0, 1, 32'hC012_3456, 0, 1, "R3");
      look(32'h8040_0000, 0, 0, 0, 0, 0, "R3");
      // R4: clean page in slot 2
      fill(32'h0000_5000, 20'h00777, 0, 0, 1, 1, 0);
      look(32'h0000_5010, 0, 1, 32'h0077_7010, 1, 1, "R4");
      look(32'h0000_5010, 1, 0, 0, 0, 0, "R4");
      look(32'h0040_1004, 1, 1, 32'hABCD_E004, 1, 0, "R4");
      // R8/R4: refill covered address, now dirty
      fill(32'h0000_5000, 20'h00777, 0, 0, 1, 1, 1);
      look(32'h0000_5010, 1, 1, 32'h0077_7010, 1, 1, "R4");
      // R6: invalidate small then large (deep inside)
      inval(32'h0040_1FFF);
      look(32'h0040_1000, 0, 0, 0, 0, 0, "R6");
      look(32'h8000_0000, 0, 1, 32'hC000_0000, 0, 1, "R6");
      look(32'h0000_5000, 0, 1, 32'h0077_7000, 1, 1, "R6");
      inval(32'h8012_3456);
      look(32'h8000_0000, 0, 0, 0, 0, 0, "R6");
      // R5: global small page (slot 0), then base write
      fill(32'h0000_9000, 20'h11111, 0, 1, 1, 0, 1);
      @(negedge clk); strobes_off(); base_wr = 1;
      look(32'h0000_5000, 0, 0, 0, 0, 0, "R5");
      look(32'h0000_9004, 0, 1, 32'h1111_1004, 1, 0, "R5");
      // R9 + R10: fill slot 1 with invalidate of G; lookup of fill address in same cycle
      @(negedge clk); strobes_off();
      set_fill(32'h0000_A000, 20'h22222, 0, 0, 0, 1, 1);
      inv_valid = 1; inv_vaddr = 32'h0000_9000;
      push_look(32'h0000_A000, 0, 0, 0, 0, 0, "R10");
      look(32'h0000_A008, 0, 1, 32'h2222_2008, 0, 1, "R9");
      look(32'h0000_9000, 0, 0, 0, 0, 0, "R9");
      // R7: fill remaining 15 slots (0, 2..15)
      for (int i = 0; i < 15; i++)
         fill(32'h0100_0000 + 32'(i) * 32'h1000, 20'h30000 + 20'(i), 0, 0, 1, 1, 1);
      look(32'h0100_E000, 0, 1, 32'h3000_E000, 1, 1, "R7");
      // full: pointer at 0 evicts slot 0 (va 0x0100_0000)
      fill(32'h0200_0000, 20'h50000, 0, 0, 1, 1, 1);
      look(32'h0100_0000, 0, 0, 0, 0, 0, "R7");
      look(32'h0000_A000, 0, 1, 32'h2222_2000, 0, 1, "R7");
      look(32'h0200_0123, 0, 1, 32'h5000_0123, 1, 1, "R7");
      // pointer at 1 evicts slot 1 (the 0xA000 page)
      fill(32'h0200_1000, 20'h50001, 0, 0, 1, 1, 1);
      look(32'h0000_A000, 0, 0, 0, 0, 0, "R7");
      look(32'h0100_1000, 0, 1, 32'h3000_1000, 1, 1, "R7");
      // R8: refill va of entry i=7 in place; pointer stays at 2
      fill(32'h0100_7000, 20'h4AAAA, 0, 0, 0, 0, 1);
      look(32'h0100_7FF0, 0, 1, 32'h4AAA_AFF0, 0, 0, "R8");
      look(32'h0100_1000, 0, 1, 32'h3000_1000, 1, 1, "R8");
      // next eviction hits slot 2 (va 0x0100_1000)
      fill(32'h0200_2000, 20'h50002, 0, 0, 1, 1, 1);
      look(32'h0100_1000, 0, 0, 0, 0, 0, "R8");
      look(32'h0100_2000, 0, 1, 32'h3000_2000, 1, 1, "R7");
      @(negedge clk); strobes_off();
      repeat (3) @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule